// File: doc/BRIEF.md
# Probe Contact Check Sequencer

The sequencer runs a dual-needle probe card. Every pad on the device under test is touched by two needles. The drive needle (A) can push a logic level onto the pad, and the sense needle (B) reads the pad back. The sequencer starts with all power and input relays open. On each period tick it pulses the A needles of the digital input pads and watches the matching B needles, which yields a contact bitmap with one bit per pad. From that bitmap it asks the chuck to rise: first in coarse steps while no pad answers, then in fine steps until every digital pad answers.

Once the inputs are aligned, the block hands over to powered mode in three steps:

1. It releases all A drivers to high impedance.
2. It puts a pull-down on the B needles of power pads and a pull-up on the B needles of ground pads.
3. On a later cycle it closes the relays and turns power on.

Power-phase checks read the B levels of the power and ground pads and keep asking for fine raises until all of them are correct. The block then disconnects the B needles of analog pads and carries on reporting every period.

Each check result leaves the block as a short burst of 32-bit words on a valid/ready stream. Eight LEDs show the phase. A pad-type table, given as a parameter, says for each pad whether it is a digital input, power, ground or analog pad.

Top module: `probe_contact_seq`

## Requirements
- R1: While reset is held, and after reset until `start` is seen, every relay is open (`relay_open` all ones), `a_drive` is zero, `power_on`, `raise_coarse`, `raise_fine` and `m_valid` are low, and `led` is zero.
- R2: An A needle is driven high only while every relay is open and power is off.
- R3: With `skip_seq` low, the digital pads are pulsed one at a time, so at most one `a_drive` bit is high in any cycle. Bitmap bit i is 1 exactly when pad i is a digital input (type code 0) whose B needle returned the pulse. Bits of all other pads are 0.
- R4: With `skip_seq` high, every digital pad is pulsed in the same cycles, and the bitmap has the same meaning as in R3.
- R5: Each check result is sent as ceil(NPAD/32) words, lowest pad first: bit b of word k is pad 32k+b, and bits beyond the last pad are 0. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold.
- R6: After an input check whose bitmap is zero, if no fine raise has been issued yet, a single one-cycle `raise_coarse` pulse follows.
- R7: After an input check that is not zero but is incomplete, or that is zero after a fine raise has already been issued, a single one-cycle `raise_fine` pulse follows. `raise_coarse` and `raise_fine` are never high together.
- R8: After an input check in which every digital pad answered, the handover runs in order. First all `a_oe` bits go low. Then the pulls switch on: `b_pull_dn` on power pads (type code 1) and `b_pull_up` on ground pads (type code 2). Then `power_on` rises and the relays close. While power is on, `a_oe` stays zero.
- R9: In a power-phase check, the bit of a power pad is its B level and the bit of a ground pad is its inverted B level. All other bits are 0. An incomplete result before completion leads to one `raise_fine` pulse. A complete result drives `b_conn` low for analog pads (type code 3) and high for all others.
- R10: Checks begin only on period ticks. After completion, consecutive reports start exactly PERIOD_CYC cycles apart.
- R11: `led[0]` means coarse stepping. `led[1]` means fine stepping before the inputs are aligned. `led[2]` means the inputs are aligned. `led[3]` means power is on. `led[4]` means complete. `led[5]` means a check is in progress. `led[6]` means a report is being sent. `led[7]` gives the result of the previous report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the sequence from idle |
| skip_seq | input | 1 | 1 pulses all digital pads together instead of one by one |
| b_in | input | NPAD | Sense-needle levels |
| m_ready | input | 1 | Stream consumer ready |
| relay_open | output | NRELAY | 1 = relay open (power and inputs isolated) |
| a_drive | output | NPAD | Drive-needle level |
| a_oe | output | NPAD | Drive-needle enable, 0 = high impedance |
| b_pull_up | output | NPAD | Pull-up enable on the sense needle |
| b_pull_dn | output | NPAD | Pull-down enable on the sense needle |
| b_conn | output | NPAD | Sense needle connected |
| power_on | output | 1 | Power connected |
| raise_coarse | output | 1 | One-cycle coarse chuck-raise request |
| raise_fine | output | 1 | One-cycle fine chuck-raise request |
| led | output | 8 | Status LEDs |
| m_data | output | 32 | Bitmap word |
| m_valid | output | 1 | Stream word valid |

## Verification
The bench models a chuck whose height rises by 4 on a coarse request and by 1 on a fine request. Each pad makes contact above its own threshold. The bench drives B from the A level, the pulls and the power state.

It targets four corner cases:
- The move from coarse to fine stepping. A design that kept issuing coarse steps would overshoot the pads.
- A zero bitmap that arrives after fine stepping has begun. A design that dropped back to coarse would be caught here.
- An order of handover that puts power on while A drivers or pulls are still in the wrong state.
- Non-digital pads inside the sequential pass. A wrong skip would light their bits or shift the bits of the next digital pad.

A case in which every pad touches at once checks that no raise is requested. Random stalls on `m_ready` catch words that are lost or reordered.

// File: rtl/probe_contact_seq.sv
module probe_contact_seq #(
  parameter int NPAD       = 103,
  parameter int NRELAY     = 17,
  parameter int PULSE_CYC  = 16,
  parameter int SETTLE_CYC = 8,
  parameter int PERIOD_CYC = 1250000,
  parameter logic [2*NPAD-1:0] PAD_TYPE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_seq,
  input  logic [NPAD-1:0]   b_in,
  input  logic              m_ready,
  output logic [NRELAY-1:0] relay_open,
  output logic [NPAD-1:0]   a_drive,
  output logic [NPAD-1:0]   a_oe,
  output logic [NPAD-1:0]   b_pull_up,
  output logic [NPAD-1:0]   b_pull_dn,
  output logic [NPAD-1:0]   b_conn,
  output logic              power_on,
  output logic              raise_coarse,
  output logic              raise_fine,
  output logic [7:0]        led,
  output logic [31:0]       m_data,
  output logic              m_valid
);
  localparam int NWORD = (NPAD + 31) / 32;
  localparam int PW    = NWORD * 32;
  localparam int IW    = $clog2(NPAD);
  localparam int CW    = $clog2(PULSE_CYC + 1);
  localparam int TW    = $clog2(PERIOD_CYC);
  localparam int WIW   = (NWORD > 1) ? $clog2(NWORD) : 1;

  function automatic logic [NPAD-1:0] type_mask(input logic [1:0] code);
    logic [NPAD-1:0] m;
    for (int i = 0; i < NPAD; i++) m[i] = (PAD_TYPE[2*i +: 2] == code);
    return m;
  endfunction

  localparam logic [NPAD-1:0] DIG_M = type_mask(2'd0);
  localparam logic [NPAD-1:0] PWR_M = type_mask(2'd1);
  localparam logic [NPAD-1:0] GND_M = type_mask(2'd2);
  localparam logic [NPAD-1:0] ANA_M = type_mask(2'd3);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SCAN, S_PCHK, S_SEND, S_HAND, S_PWRON} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [WIW-1:0]  wi;
  logic [TW-1:0]   tcnt;
  logic [NPAD-1:0] bitmap, b_s1, b_s2;
  logic            allmode, fine, aligned, pulls, pwr, done, rc, rf, last_ok;

  wire             tick    = (tcnt == '0);
  wire             at_set  = (cnt == CW'(SETTLE_CYC));
  wire             at_end  = (cnt == CW'(PULSE_CYC - 1));
  wire             at_last = (idx == IW'(NPAD - 1));
  wire [NPAD-1:0]  one     = {{(NPAD-1){1'b0}}, 1'b1} << idx;
  wire             ok      = (bitmap == (pwr ? (PWR_M | GND_M) : DIG_M));
  wire [PW-1:0]    padded  = PW'(bitmap);

  assign relay_open   = {NRELAY{~pwr}};
  assign power_on     = pwr;
  assign a_drive      = (st == S_SCAN) ? (allmode ? DIG_M : (DIG_M & one)) : '0;
  assign a_oe         = aligned ? '0 : DIG_M;
  assign b_pull_dn    = pulls ? PWR_M : '0;
  assign b_pull_up    = pulls ? GND_M : '0;
  assign b_conn       = done ? ~ANA_M : '1;
  assign raise_coarse = rc;
  assign raise_fine   = rf;
  assign m_valid      = (st == S_SEND);
  assign m_data       = padded[32*int'(wi) +: 32];
  assign led = {last_ok, m_valid, (st == S_SCAN) || (st == S_PCHK), done, pwr, aligned,
                fine && !aligned, (st != S_IDLE) && !fine && !aligned};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; wi <= '0; tcnt <= TW'(PERIOD_CYC - 1);
      bitmap <= '0; b_s1 <= '0; b_s2 <= '0;
      allmode <= 1'b0; fine <= 1'b0; aligned <= 1'b0; pulls <= 1'b0;
      pwr <= 1'b0; done <= 1'b0; rc <= 1'b0; rf <= 1'b0; last_ok <= 1'b0;
    end else begin
      b_s1 <= b_in;
      b_s2 <= b_s1;
      rc   <= 1'b0;
      rf   <= 1'b0;
      if (st == S_IDLE || tick) tcnt <= TW'(PERIOD_CYC - 1);
      else                      tcnt <= tcnt - 1'b1;
      case (st)
        S_IDLE: if (start) st <= S_WAIT;
        S_WAIT: if (tick) begin
          cnt <= '0;
          idx <= '0;
          if (pwr) st <= S_PCHK;
          else begin
            bitmap  <= '0;
            allmode <= skip_seq;
            st      <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (allmode) begin
            if (at_set) bitmap <= b_s2 & DIG_M;
            if (at_end) begin cnt <= '0; st <= S_SEND; end
            else cnt <= cnt + 1'b1;
          end else if (!DIG_M[idx]) begin
            if (at_last) st <= S_SEND;
            else idx <= idx + 1'b1;
          end else begin
            if (at_set) bitmap[idx] <= b_s2[idx];
            if (at_end) begin
              cnt <= '0;
              if (at_last) st <= S_SEND;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_PCHK: begin
          if (at_set) begin
            bitmap <= (PWR_M & b_s2) | (GND_M & ~b_s2);
            st     <= S_SEND;
          end else cnt <= cnt + 1'b1;
        end
        S_SEND: if (m_ready) begin
          if (wi == WIW'(NWORD - 1)) begin
            wi      <= '0;
            last_ok <= ok;
            st      <= S_WAIT;
            if (!pwr) begin
              if (ok) begin aligned <= 1'b1; st <= S_HAND; end
              else if (bitmap == '0 && !fine) rc <= 1'b1;
              else begin fine <= 1'b1; rf <= 1'b1; end
            end else if (ok) done <= 1'b1;
            else if (!done) rf <= 1'b1;
          end else wi <= wi + 1'b1;
        end
        S_HAND:  begin pulls <= 1'b1; st <= S_PWRON; end
        S_PWRON: begin pwr <= 1'b1; st <= S_WAIT; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module probe_contact_seq_chk #(
  parameter int NPAD   = 103,
  parameter int NRELAY = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NRELAY-1:0] relay_open,
  input logic [NPAD-1:0]   a_drive,
  input logic [NPAD-1:0]   a_oe,
  input logic              power_on,
  input logic              raise_coarse,
  input logic              raise_fine,
  input logic [31:0]       m_data,
  input logic              m_valid,
  input logic              m_ready
);
  a_r2_drive_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drive != '0) |-> ((&relay_open) && !power_on));
  a_r8_power_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    power_on |-> (a_oe == '0));
  a_r8_hiz_before_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_on) |-> ($past(a_oe) == '0));
  a_r7_single_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({raise_coarse, raise_fine}));
  a_r6_coarse_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    raise_coarse |-> !power_on);
  a_r5_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

bind probe_contact_seq probe_contact_seq_chk #(.NPAD(NPAD), .NRELAY(NRELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .relay_open(relay_open), .a_drive(a_drive), .a_oe(a_oe),
  .power_on(power_on), .raise_coarse(raise_coarse), .raise_fine(raise_fine),
  .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready));

// File: tb/probe_contact_seq_tb.sv
module probe_contact_seq_tb_top;
  localparam int NPAD = 103, NRELAY = 17, PULSE = 6, SETTLE = 3, PERIOD = 600, NWORD = 4;

  function automatic logic [1:0] ptype(input int i);
    case (i % 10)
      3: return 2'd1;
      7: return 2'd2;
      9: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
  function automatic logic [2*NPAD-1:0] mk_types();
    logic [2*NPAD-1:0] t;
    for (int i = 0; i < NPAD; i++) t[2*i +: 2] = ptype(i);
    return t;
  endfunction
  function automatic logic [NPAD-1:0] mk_mask(input logic [1:0] c);
    logic [NPAD-1:0] m;
    for (int i = 0; i < NPAD; i++) m[i] = (ptype(i) == c);
    return m;
  endfunction
  localparam logic [NPAD-1:0] DIGV = mk_mask(2'd0), PWRV = mk_mask(2'd1);
  localparam logic [NPAD-1:0] GNDV = mk_mask(2'd2), ANAV = mk_mask(2'd3);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, skip_seq = 1'b0, m_ready = 1'b0;
  logic [NPAD-1:0] b_in, a_drive, a_oe, b_pull_up, b_pull_dn, b_conn, contact;
  logic [NRELAY-1:0] relay_open;
  logic power_on, raise_coarse, raise_fine, m_valid;
  logic [7:0] led;
  logic [31:0] m_data;

  always #4 clk = ~clk;

  probe_contact_seq #(.NPAD(NPAD), .NRELAY(NRELAY), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE),
    .PERIOD_CYC(PERIOD), .PAD_TYPE(mk_types())) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_seq(skip_seq), .b_in(b_in), .m_ready(m_ready),
    .relay_open(relay_open), .a_drive(a_drive), .a_oe(a_oe), .b_pull_up(b_pull_up),
    .b_pull_dn(b_pull_dn), .b_conn(b_conn), .power_on(power_on), .raise_coarse(raise_coarse),
    .raise_fine(raise_fine), .led(led), .m_data(m_data), .m_valid(m_valid));

  assign b_in = (DIGV & a_oe & a_drive & contact) | (PWRV & {NPAD{power_on}} & contact)
              | (GNDV & b_pull_up & ~contact);

  int nchk = 0, nfail = 0, cyc = 0;
  bit wd = 1'b0;
  int thr [NPAD];
  int h, wcnt, exp_act, ndone_rep, last_rise;
  bit phase, fine_iss, done_seen, prev_pwr, prev_valid, prev_ok, rep_done_phase, last_done_phase;
  logic [127:0] rxv;

  task automatic chk(input bit good, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NPAD-1:0] exp_map(input bit pw);
    logic [NPAD-1:0] m;
    for (int i = 0; i < NPAD; i++) m[i] = (pw ? (PWRV[i] | GNDV[i]) : DIGV[i]) & contact[i];
    return m;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000 && !wd) begin
      wd = 1'b1;
      chk(1'b0, "watchdog", 128'(cyc), 128'd190000);
    end
    if (!rst_n) begin
      h = 0; wcnt = 0; exp_act = 0; ndone_rep = 0; last_rise = 0; fine_iss = 0; done_seen = 0;
      prev_pwr = 0; prev_valid = 0; prev_ok = 0; rep_done_phase = 0; last_done_phase = 0;
      rxv = '0; m_ready = 1'b0;
    end else begin
      if (raise_coarse) begin
        chk(exp_act == 1, "R6 coarse raise", 128'(exp_act), 128'd1);
        exp_act = 0; h = h + 4;
      end
      if (raise_fine) begin
        chk(exp_act == 2, "R7 fine raise", 128'(exp_act), 128'd2);
        exp_act = 0; h = h + 1;
        if (!power_on) fine_iss = 1;
      end
      if (power_on && !prev_pwr) begin
        chk(exp_act == 3, "R8 power on after aligned", 128'(exp_act), 128'd3);
        chk(b_pull_dn == PWRV && b_pull_up == GNDV && a_oe == '0 && relay_open == '0,
            "R8 handover state", 128'({b_pull_dn, b_pull_up}), 128'({PWRV, GNDV}));
        exp_act = 0;
      end
      prev_pwr = power_on;
      if (b_conn != '1 && !done_seen) begin
        done_seen = 1;
        chk(b_conn == ~ANAV, "R9 analog disconnect", 128'(b_conn), 128'(~ANAV));
      end
      for (int i = 0; i < NPAD; i++) contact[i] = (h >= thr[i]);
      if (a_drive != '0) begin
        chk((&relay_open) && !power_on, "R2 isolated drive", 128'({power_on, relay_open}),
            128'({1'b0, {NRELAY{1'b1}}}));
        if (skip_seq) chk(a_drive == DIGV, "R4 all together", 128'(a_drive), 128'(DIGV));
        else chk($countones(a_drive) == 1, "R3 one at a time", 128'($countones(a_drive)), 128'd1);
      end
      if (m_valid && !prev_valid) begin
        chk(exp_act == 0, "R6/R7 missed request", 128'(exp_act), 128'd0);
        rep_done_phase = done_seen;
        if (rep_done_phase && last_done_phase)
          chk(cyc - last_rise == PERIOD, "R10 period", 128'(cyc - last_rise), 128'(PERIOD));
        last_rise = cyc; last_done_phase = rep_done_phase;
      end
      prev_valid = m_valid;
      m_ready = ($urandom % 2) == 0;
      if (m_valid && m_ready) begin
        if (wcnt == 0) phase = power_on;
        rxv[32*wcnt +: 32] = m_data;
        wcnt++;
        if (wcnt == NWORD) begin
          logic [NPAD-1:0] got, ex;
          bit ok;
          wcnt = 0;
          got = rxv[NPAD-1:0];
          ex = exp_map(phase);
          chk(got == ex, phase ? "R9 power bitmap" : (skip_seq ? "R4 bitmap" : "R3 bitmap"),
              128'(got), 128'(ex));
          chk(rxv[127:NPAD] == '0, "R5 padding", 128'(rxv[127:NPAD]), 128'd0);
          chk(led[6:2] == {1'b1, 1'b0, done_seen, phase, phase} &&
              led[1:0] == {fine_iss && !phase, !fine_iss && !phase} && led[7] == prev_ok,
              "R11 leds", 128'(led),
              128'({prev_ok, 1'b1, 1'b0, done_seen, phase, phase, fine_iss && !phase, !fine_iss && !phase}));
          ok = got == (phase ? (PWRV | GNDV) : DIGV);
          prev_ok = ok;
          if (!phase) exp_act = ok ? 3 : ((got == '0 && !fine_iss) ? 1 : 2);
          else exp_act = (ok || done_seen) ? 0 : 2;
          if (rep_done_phase) ndone_rep++;
        end
      end
    end
  end

  task automatic run_scn(input bit skip, input int mode);
    rst_n = 1'b0; start = 1'b0; skip_seq = skip;
    for (int i = 0; i < NPAD; i++)
      thr[i] = (mode == 0) ? 0 : (DIGV[i] ? 5 + int'($urandom % 12) : int'($urandom % 21));
    repeat (3) @(negedge clk);
    chk(relay_open == '1 && a_drive == '0 && !power_on && !m_valid && led == 8'd0,
        "R1 reset state", 128'({relay_open, led}), 128'({{NRELAY{1'b1}}, 8'd0}));
    rst_n = 1'b1;
    repeat (PERIOD + 20) @(negedge clk);
    chk(a_drive == '0 && !raise_coarse && !raise_fine && !m_valid && led == 8'd0,
        "R1 idle before start", 128'({m_valid, led}), 128'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (ndone_rep < 3 && !wd) @(negedge clk);
    chk(led[4] && power_on && b_conn == ~ANAV, "R9 completed", 128'(led), 128'h18);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NPAD; i++) thr[i] = 0;
    run_scn(1'b0, 1);
    if (!wd) run_scn(1'b1, 1);
    if (!wd) run_scn(1'b0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule